// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches eight external interrupt pins and one non-maskable interrupt pin and turns the events on them into active-high request levels for a downstream interrupt controller. Software picks the sense of each of the eight pins with a 2-bit code: low level, falling edge, rising edge or both edges. An edge event is held in a request flag until software clears it. In low-level sense the flag simply shows the inverted pin. The non-maskable pin has its own rising or falling edge select, a flag, and a read-only copy of its synchronised level.

Software reaches the block over a small 16-bit register bus. The bus has a byte address, read and write strobes, write data, and combinational read data that is valid while the read strobe is high. Every pin goes through a two-flop synchroniser before detection. The asynchronous active-low reset is released synchronously inside the block. Prioritisation, masking and vectoring are left to the downstream controller.

Top module: `ext_irq_sense_ctrl`

## Requirements
- R1: After reset, every sense field, every request flag and the edge select of the non-maskable pin are zero, and `irq_req` and `nmi_req` are low.
- R2: The sense register at byte offset 2 holds pin n's code in bits 2n+1:2n and reads back what was written.
- R3: Sense code 0 (low level) makes a pin's flag equal the inverse of its synchronised level. A clear-write cannot remove it while the pin is low, and it drops when the pin returns high.
- R4: Sense code 1 latches a flag on a falling edge and ignores a rising edge.
- R5: Sense code 2 latches a flag on a rising edge and ignores a falling edge.
- R6: Sense code 3 latches a flag on either edge.
- R7: The request register at byte offset 4 shows pin n's flag in bit n, with bits 15:8 reading zero. Writing 0 to a bit clears that latched flag, and writing 1 leaves it unchanged. Each flag drives `irq_req[n]` as an active-high level.
- R8: An edge detected in the same cycle as a clear-write to its bit leaves the flag set.
- R9: In the control register of the non-maskable pin at byte offset 0, bit 15 reads the synchronised pin level, and writes to that bit are ignored.
- R10: Bit 8 of that register selects the edge of the non-maskable pin (0 falling, 1 rising). A matching edge sets bit 1, which drives `nmi_req`. The other edge does not set it.
- R11: Writing 0 to bit 1 of the control register at offset 0 clears the flag of the non-maskable pin, and writing 1 leaves it unchanged.
- R12: A pin change reaches its request output within five clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, zero when not reading |
| irq_pin | input | 8 | Raw external interrupt pins |
| nmi_pin | input | 1 | Raw non-maskable interrupt pin |
| irq_req | output | 8 | Active-high request level per pin |
| nmi_req | output | 1 | Active-high request of the non-maskable pin |

## Verification
The bench lands an edge in exactly the cycle that a clear-write reaches the same flag. A design that lets the clear win there loses the event and leaves the request low. It writes a mix of ones and zeros to the request register to show that only the zero bits clear. A design that treats a written one as a clear, or clears the whole byte, drops the neighbouring flag. It also tries to clear a low-level flag while its pin is still low, which a design that latches level events would wrongly allow. On the non-maskable side it writes a one to the read-only level bit and drives the edge opposite to the one selected, so a design whose edge polarity is swapped raises a request it should not.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'd0,
    SENSE_FALL = 2'd1,
    SENSE_RISE = 2'd2,
    SENSE_BOTH = 2'd3
  } sense_e;

  localparam int REG_W   = 16;
  localparam int ADDR_W  = 3;
  localparam int NUM_IRQ = 8;

  localparam logic [ADDR_W-1:0] OFS_NMI   = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_SENSE = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_REQ   = 3'd4;

  localparam int NMI_LVL_BIT  = 15;
  localparam int NMI_EDGE_BIT = 8;
  localparam int NMI_FLAG_BIT = 1;

endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_n_sync <= meta_q;
    end
  end
endmodule

// File: rtl/sync_2ff.sv
module sync_2ff #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/irq_sense_chan.sv
module irq_sense_chan
  import ext_irq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   lvl,
  input  sense_e sense,
  input  logic   clr,
  output logic   flag
);
  logic lvl_d;
  logic rise, fall, hit;
  logic flag_d;

  assign rise = lvl & ~lvl_d;
  assign fall = ~lvl & lvl_d;

  always_comb begin
    hit = 1'b0;
    unique case (sense)
      SENSE_FALL: hit = fall;
      SENSE_RISE: hit = rise;
      SENSE_BOTH: hit = rise | fall;
      default:    hit = 1'b0;
    endcase
    if (sense == SENSE_LOW) flag_d = ~lvl;
    else                    flag_d = hit | (flag & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_d <= 1'b0;
      flag  <= 1'b0;
    end else begin
      lvl_d <= lvl;
      flag  <= flag_d;
    end
  end

  // R8
  edge_beats_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sense != SENSE_LOW && hit) |=> flag);

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sense != SENSE_LOW && flag && !clr) |=> flag);

  // R3
  low_level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sense == SENSE_LOW && !lvl) |=> flag);
endmodule

// File: rtl/nmi_chan.sv
module nmi_chan (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  input  logic rise_sel,
  input  logic clr,
  output logic flag
);
  logic lvl_d;
  logic hit;
  logic flag_d;

  always_comb begin
    hit    = rise_sel ? (lvl & ~lvl_d) : (~lvl & lvl_d);
    flag_d = hit | (flag & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_d <= 1'b0;
      flag  <= 1'b0;
    end else begin
      lvl_d <= lvl;
      flag  <= flag_d;
    end
  end

  // R10
  nmi_set_by_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(hit));

  // R11
  nmi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
endmodule

// File: rtl/ext_irq_sense_ctrl.sv
module ext_irq_sense_ctrl
  import ext_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [NUM_IRQ-1:0] irq_pin,
  input  logic              nmi_pin,
  output logic [NUM_IRQ-1:0] irq_req,
  output logic              nmi_req
);
  localparam int SENSE_W = 2 * NUM_IRQ;

  logic               rst_n_i;
  logic [NUM_IRQ-1:0] irq_lvl;
  logic               nmi_lvl;
  logic [SENSE_W-1:0] sense_q, sense_d;
  logic               nmi_edge_q, nmi_edge_d;
  logic               wr_sense, wr_req, wr_nmi;
  logic [NUM_IRQ-1:0] req_clr;
  logic               nmi_clr;
  logic [NUM_IRQ-1:0] flags;
  logic               nmi_flag;

  rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  sync_2ff #(.W(NUM_IRQ + 1)) u_sync (
    .clk(clk), .rst_n(rst_n_i),
    .d({nmi_pin, irq_pin}),
    .q({nmi_lvl, irq_lvl})
  );

  assign wr_sense = bus_wr && (bus_addr == OFS_SENSE);
  assign wr_req   = bus_wr && (bus_addr == OFS_REQ);
  assign wr_nmi   = bus_wr && (bus_addr == OFS_NMI);

  always_comb begin
    sense_d    = sense_q;
    nmi_edge_d = nmi_edge_q;
    if (wr_sense) sense_d    = bus_wdata[SENSE_W-1:0];
    if (wr_nmi)   nmi_edge_d = bus_wdata[NMI_EDGE_BIT];
    req_clr = wr_req ? ~bus_wdata[NUM_IRQ-1:0] : '0;
    nmi_clr = wr_nmi && !bus_wdata[NMI_FLAG_BIT];
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sense_q    <= '0;
      nmi_edge_q <= 1'b0;
    end else begin
      sense_q    <= sense_d;
      nmi_edge_q <= nmi_edge_d;
    end
  end

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_chan
    irq_sense_chan u_chan (
      .clk(clk), .rst_n(rst_n_i),
      .lvl(irq_lvl[g]),
      .sense(sense_e'(sense_q[2*g+1:2*g])),
      .clr(req_clr[g]),
      .flag(flags[g])
    );
  end

  nmi_chan u_nmi (
    .clk(clk), .rst_n(rst_n_i),
    .lvl(nmi_lvl), .rise_sel(nmi_edge_q),
    .clr(nmi_clr), .flag(nmi_flag)
  );

  assign irq_req = flags;
  assign nmi_req = nmi_flag;

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      unique case (bus_addr)
        OFS_NMI: begin
          bus_rdata[NMI_LVL_BIT]  = nmi_lvl;
          bus_rdata[NMI_EDGE_BIT] = nmi_edge_q;
          bus_rdata[NMI_FLAG_BIT] = nmi_flag;
        end
        OFS_SENSE: bus_rdata[SENSE_W-1:0] = sense_q;
        OFS_REQ:   bus_rdata[NUM_IRQ-1:0] = flags;
        default:   bus_rdata = '0;
      endcase
    end
  end

  // R7
  req_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    (bus_rd && bus_addr == OFS_REQ) |-> (bus_rdata[REG_W-1:NUM_IRQ] == '0));
endmodule

// File: tb/ext_irq_sense_ctrl_tb.sv
module ext_irq_sense_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [7:0]  irq_pin = 8'hFF;
  logic        nmi_pin = 1'b1;
  logic [7:0]  irq_req;
  logic        nmi_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [2:0] A_NMI = 3'd0, A_SENSE = 3'd2, A_REQ = 3'd4;

  // {mode[1:0], pin before, pin after, expected request}
  localparam logic [4:0] VEC [8] = '{
    5'b01_1_0_1, 5'b01_0_1_0, 5'b10_0_1_1, 5'b10_1_0_0,
    5'b11_1_0_1, 5'b11_0_1_1, 5'b00_1_0_1, 5'b00_0_1_0
  };

  always #5 clk = ~clk;

  ext_irq_sense_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_pin(irq_pin), .nmi_pin(nmi_pin), .irq_req(irq_req), .nmi_req(nmi_req)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [2:0] a, input logic [15:0] exp);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    check(req, bus_rdata, exp);
    bus_rd = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(6);

    // R1 reset state
    check("R1 irq_req", {8'h0, irq_req}, 16'h0);
    check("R1 nmi_req", {15'h0, nmi_req}, 16'h0);
    rd_check("R1 nmi reg", A_NMI, 16'h8000);
    rd_check("R1 sense reg", A_SENSE, 16'h0000);
    rd_check("R1 req reg", A_REQ, 16'h0000);

    // R2 readback
    wr(A_SENSE, 16'h1B4E);
    wait_n(5);
    rd_check("R2 sense readback", A_SENSE, 16'h1B4E);
    rd_check("R2 no events", A_REQ, 16'h0000);
    wr(A_SENSE, 16'h0000);

    // R3 R4 R5 R6 R12 vector walk
    for (int i = 0; i < 8; i++) begin
      int ch;
      ch = (i * 3) % 8;
      wr(A_SENSE, 16'(VEC[i][4:3]) << (2 * ch));
      irq_pin[ch] = VEC[i][2];
      wait_n(5);
      wr(A_REQ, 16'h0000);
      wait_n(2);
      irq_pin[ch] = VEC[i][1];
      wait_n(5);
      check($sformatf("R3-6/R12 vec%0d mode%0d ch%0d", i, VEC[i][4:3], ch),
            {15'h0, irq_req[ch]}, {15'h0, VEC[i][0]});
      check($sformatf("R4 R5 R6 vec%0d others quiet", i),
            {8'h0, irq_req & ~(8'h1 << ch)}, 16'h0);
      wr(A_SENSE, 16'h0000);
      irq_pin[ch] = 1'b1;
      wait_n(5);
    end

    // R7 selective clear
    wr(A_SENSE, 16'h0820);
    irq_pin[2] = 1'b0; irq_pin[5] = 1'b0;
    wait_n(5);
    irq_pin[2] = 1'b1; irq_pin[5] = 1'b1;
    wait_n(5);
    rd_check("R7 two flags", A_REQ, 16'h0024);
    check("R7 irq_req", {8'h0, irq_req}, 16'h0024);
    wr(A_REQ, 16'hFFFB);
    rd_check("R7 clear bit2 only", A_REQ, 16'h0020);
    wr(A_REQ, 16'hFFFF);
    rd_check("R7 ones keep", A_REQ, 16'h0020);
    wr(A_REQ, 16'h00DF);
    rd_check("R7 clear bit5", A_REQ, 16'h0000);
    wr(A_SENSE, 16'h0000);

    // R3 low level not clearable
    irq_pin[1] = 1'b0;
    wait_n(5);
    check("R3 low sets", {15'h0, irq_req[1]}, 16'h1);
    wr(A_REQ, 16'h00FD);
    wait_n(2);
    check("R3 clear ignored while low", {15'h0, irq_req[1]}, 16'h1);
    irq_pin[1] = 1'b1;
    wait_n(5);
    check("R3 drops when high", {15'h0, irq_req[1]}, 16'h0);

    // R8 edge coincides with clear
    wr(A_SENSE, 16'h0003);
    irq_pin[0] = 1'b0;
    wait_n(5);
    check("R8 first edge", {15'h0, irq_req[0]}, 16'h1);
    irq_pin[0] = 1'b1;
    wait_n(2);
    wr(A_REQ, 16'h00FE);
    wait_n(1);
    check("R8 edge wins over clear", {15'h0, irq_req[0]}, 16'h1);
    wr(A_REQ, 16'h00FE);
    wait_n(1);
    check("R8 later clear works", {15'h0, irq_req[0]}, 16'h0);
    wr(A_SENSE, 16'h0000);

    // R10 R9 R11 non-maskable path
    nmi_pin = 1'b0;
    wait_n(5);
    check("R10 falling sets", {15'h0, nmi_req}, 16'h1);
    rd_check("R9 R10 nmi reg low", A_NMI, 16'h0002);
    wr(A_NMI, 16'h8002);
    rd_check("R9 R11 bit15 ignored, one keeps", A_NMI, 16'h0002);
    wr(A_NMI, 16'h0000);
    rd_check("R11 clear", A_NMI, 16'h0000);
    check("R11 nmi_req low", {15'h0, nmi_req}, 16'h0);
    wr(A_NMI, 16'h0100);
    nmi_pin = 1'b1;
    wait_n(5);
    rd_check("R10 rising sets", A_NMI, 16'h8102);
    wr(A_NMI, 16'h0100);
    rd_check("R11 clear keeps edge", A_NMI, 16'h8100);
    nmi_pin = 1'b0;
    wait_n(5);
    rd_check("R10 falling ignored when rising", A_NMI, 16'h0100);
    check("R10 nmi_req stays low", {15'h0, nmi_req}, 16'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule